// File: doc/BRIEF.md
# Slot-Masked TDM Serial Transmitter

This block sends one serial word per time slot of a time-division-multiplexed frame. The frame begins when the frame-sync input rises. From then on, a word boundary falls every `WORD_W` cycles of a continuous bit clock. At each boundary a per-slot enable mask decides the next slot. An enabled slot copies the holding register into a shift register and drives it onto the line, most significant bit first. A disabled slot releases the line and leaves every piece of state untouched.

The host keeps the block fed through a holding-register write strobe. A second strobe, the time-slot write, also counts as servicing the slot, but it keeps the line released for that slot. An empty flag, with an optional interrupt, asks for the next word. If an enabled slot arrives with no write since the last enabled load, a sticky underrun flag is raised and the stale word is sent again with the line driven.

Top module: `tdm_slot_tx`

## Requirements
- R1: A frame starts on the bit-clock edge where `fsync` is sampled 1 after having been 0. The first bit of slot 0 is on `sdo` right after that edge. A new rising `fsync` in the middle of a frame restarts the frame at slot 0.
- R2: A word boundary occurs every `WORD_W` bit-clock cycles. At each boundary, the slot that follows uses `slot_mask[i]`, where i is that slot's index. After slot `SLOTS-1` ends, `sdo_oe` is 0 until the next frame start.
- R3: In an enabled slot, the holding register contents are sent MSB first, one bit per bit-clock cycle, with `sdo_oe` = 1 for all `WORD_W` cycles.
- R4: In a disabled slot, `sdo_oe` = 0 and `sdo` = 0. The flags and the write history are left unchanged.
- R5: `empty_flag` is set when an enabled slot loads. It is cleared by `hold_wr` or `slot_wr`. A write in the same cycle as a load wins, so the flag reads 0 and the word being loaded is the value held before that write.
- R6: `irq` is 1 exactly when `empty_flag` is 1 and `irq_en` is 1.
- R7: If an enabled slot loads with no write since the previous enabled load, `urun_flag` is set and the old holding word is sent again with `sdo_oe` = 1.
- R8: `urun_flag` stays set until a `urun_clr` pulse. A new underrun in the same cycle as a clear wins.
- R9: If the most recent write since the previous enabled load was `slot_wr`, the next enabled slot keeps `sdo_oe` = 0 and does not raise an underrun.
- R10: After reset: `empty_flag` = 1, `urun_flag` = 0, `sdo_oe` = 0, `sdo` = 0, and the holding register is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Continuous bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fsync | input | 1 | Frame sync, one word long |
| slot_mask | input | SLOTS | Per-slot enable, bit i for slot i |
| hold_wr | input | 1 | Write strobe for the holding register |
| hold_data | input | WORD_W | Data for the holding register |
| slot_wr | input | 1 | Time-slot write strobe (serviced, line released) |
| irq_en | input | 1 | Interrupt enable |
| urun_clr | input | 1 | Clears the underrun flag |
| sdo | output | 1 | Serial data, 0 when not driven |
| sdo_oe | output | 1 | Output enable for the data line |
| empty_flag | output | 1 | Holding register needs a new word |
| irq | output | 1 | Transmit interrupt request |
| urun_flag | output | 1 | Sticky underrun flag |

## Verification
Line outputs are registered. The first bit of a frame appears one edge after `fsync` is first sampled high. Each later bit is due one edge after the previous one, and the slot decision takes effect on the same edge as its boundary. The flags move one edge after the write, clear or load that causes them, and `irq` follows `empty_flag` with no added delay. All inputs are driven on the falling edge, and every result is sampled on the falling edge after the rising edge that produced it. The bench walks each frame bit by bit against a slot-level model of the write history, so every cycle of every slot is compared at the moment it is due.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;

   // minimum-one width helper for counters and indices
   function automatic int cnt_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

   // kind of the most recent host write since the last enabled load
   typedef enum logic [1:0] {
      WK_NONE = 2'd0,
      WK_HOLD = 2'd1,
      WK_SLOT = 2'd2
   } wr_kind_e;

endpackage

// File: rtl/tdm_slot_timer.sv
module tdm_slot_timer #(
   parameter int SLOTS  = 5,
   parameter int WORD_W = 8,
   localparam int SLOT_W = tdm_tx_pkg::cnt_width(SLOTS),
   localparam int BIT_W  = tdm_tx_pkg::cnt_width(WORD_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fsync,
   output logic              boundary_o,
   output logic              load_o,
   output logic [SLOT_W-1:0] slot_nxt_o
);

   localparam logic [BIT_W-1:0]  LAST_BIT  = BIT_W'(WORD_W - 1);
   localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

   logic              fsync_q;
   logic              running_q;
   logic [SLOT_W-1:0] slot_q;
   logic [BIT_W-1:0]  bit_q;
   logic              start;
   logic              word_end;

   assign start      = fsync & ~fsync_q;
   assign word_end   = running_q & (bit_q == LAST_BIT);
   assign boundary_o = start | word_end;
   assign load_o     = start | (word_end & (slot_q != LAST_SLOT));
   assign slot_nxt_o = start ? '0 : slot_q + 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fsync_q   <= 1'b0;
         running_q <= 1'b0;
         slot_q    <= '0;
         bit_q     <= '0;
      end else begin
         fsync_q <= fsync;
         if (load_o) begin
            running_q <= 1'b1;
            slot_q    <= slot_nxt_o;
            bit_q     <= '0;
         end else if (word_end) begin
            running_q <= 1'b0;
            bit_q     <= '0;
         end else if (running_q) begin
            bit_q <= bit_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/tdm_host_regs.sv
module tdm_host_regs #(
   parameter int WORD_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hold_wr,
   input  logic [WORD_W-1:0] hold_data,
   input  logic              slot_wr,
   input  logic              irq_en,
   input  logic              urun_clr,
   input  logic              load_active,
   output logic [WORD_W-1:0] hold_q_o,
   output logic              drive_o,
   output logic              empty_o,
   output logic              irq_o,
   output logic              urun_o
);

   import tdm_tx_pkg::*;

   wr_kind_e    last_q;
   wr_kind_e    wr_now;
   logic        wr_any;

   assign wr_any = hold_wr | slot_wr;
   always_comb begin
      if (hold_wr)      wr_now = WK_HOLD;
      else if (slot_wr) wr_now = WK_SLOT;
      else              wr_now = WK_NONE;
   end

   // decision for a load in this cycle, from the history before this edge
   assign drive_o = (last_q != WK_SLOT);
   assign irq_o   = empty_o & irq_en;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_q_o <= '0;
         last_q   <= WK_NONE;
         empty_o  <= 1'b1;
         urun_o   <= 1'b0;
      end else begin
         if (hold_wr) hold_q_o <= hold_data;

         if (load_active)  last_q <= wr_now;
         else if (wr_any)  last_q <= wr_now;

         if (wr_any)           empty_o <= 1'b0;
         else if (load_active) empty_o <= 1'b1;

         if (load_active && last_q == WK_NONE) urun_o <= 1'b1;
         else if (urun_clr)                    urun_o <= 1'b0;
      end
   end

endmodule

// File: rtl/tdm_word_shifter.sv
module tdm_word_shifter #(
   parameter int WORD_W    = 8,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              boundary,
   input  logic              load,
   input  logic              enable,
   input  logic [WORD_W-1:0] word_in,
   output logic              sdo_o,
   output logic              oe_o
);

   logic [WORD_W-1:0] sh_q;
   logic [WORD_W-1:0] sh_next;
   logic              out_bit;

   generate
      if (MSB_FIRST) begin : g_msb
         assign out_bit = sh_q[WORD_W-1];
         assign sh_next = {sh_q[WORD_W-2:0], 1'b0};
      end else begin : g_lsb
         assign out_bit = sh_q[0];
         assign sh_next = {1'b0, sh_q[WORD_W-1:1]};
      end
   endgenerate

   assign sdo_o = oe_o & out_bit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_q <= '0;
         oe_o <= 1'b0;
      end else if (load) begin
         if (enable) sh_q <= word_in;
         oe_o <= enable;
      end else begin
         sh_q <= sh_next;
         if (boundary) oe_o <= 1'b0;
      end
   end

endmodule

// File: rtl/tdm_slot_tx.sv
module tdm_slot_tx #(
   parameter int SLOTS     = 5,
   parameter int WORD_W    = 8,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fsync,
   input  logic [SLOTS-1:0]  slot_mask,
   input  logic              hold_wr,
   input  logic [WORD_W-1:0] hold_data,
   input  logic              slot_wr,
   input  logic              irq_en,
   input  logic              urun_clr,
   output logic              sdo,
   output logic              sdo_oe,
   output logic              empty_flag,
   output logic              irq,
   output logic              urun_flag
);

   localparam int SLOT_W = tdm_tx_pkg::cnt_width(SLOTS);

   generate
      if (SLOTS < 1) begin : g_bad_slots
         $error("SLOTS must be at least 1");
      end
      if (WORD_W < 2) begin : g_bad_word
         $error("WORD_W must be at least 2");
      end
   endgenerate

   logic              boundary;
   logic              load;
   logic [SLOT_W-1:0] slot_nxt;
   logic [SLOTS-1:0]  slot_hit;
   logic              slot_en;
   logic              load_active;
   logic              drive;
   logic [WORD_W-1:0] hold_q;

   tdm_slot_timer #(.SLOTS(SLOTS), .WORD_W(WORD_W)) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .fsync      (fsync),
      .boundary_o (boundary),
      .load_o     (load),
      .slot_nxt_o (slot_nxt)
   );

   // per-slot mask select
   generate
      for (genvar i = 0; i < SLOTS; i++) begin : g_mask
         assign slot_hit[i] = slot_mask[i] & (slot_nxt == SLOT_W'(i));
      end
   endgenerate

   assign slot_en     = |slot_hit;
   assign load_active = load & slot_en;

   tdm_host_regs #(.WORD_W(WORD_W)) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .hold_wr     (hold_wr),
      .hold_data   (hold_data),
      .slot_wr     (slot_wr),
      .irq_en      (irq_en),
      .urun_clr    (urun_clr),
      .load_active (load_active),
      .hold_q_o    (hold_q),
      .drive_o     (drive),
      .empty_o     (empty_flag),
      .irq_o       (irq),
      .urun_o      (urun_flag)
   );

   tdm_word_shifter #(.WORD_W(WORD_W), .MSB_FIRST(MSB_FIRST)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .boundary (boundary),
      .load     (load),
      .enable   (load_active & drive),
      .word_in  (hold_q),
      .sdo_o    (sdo),
      .oe_o     (sdo_oe)
   );

endmodule

// File: rtl/tdm_slot_tx_chk.sv
module tdm_slot_tx_chk #(
   parameter int SLOTS  = 5,
   parameter int WORD_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             fsync,
   input logic [SLOTS-1:0] slot_mask,
   input logic             hold_wr,
   input logic             slot_wr,
   input logic             irq_en,
   input logic             urun_clr,
   input logic             sdo,
   input logic             sdo_oe,
   input logic             empty_flag,
   input logic             irq,
   input logic             urun_flag
);

   // R4: a released line carries no data
   a_r4_quiet_line: assert property (@(posedge clk) disable iff (!rst_n)
      !sdo_oe |-> !sdo);

   // R2: a frame start into a masked slot 0 leaves the line released
   a_r2_masked_slot0: assert property (@(posedge clk) disable iff (!rst_n)
      (fsync && !$past(fsync) && !slot_mask[0]) |=> !sdo_oe);

   // R5: any host write leaves the empty flag low on the next cycle
   a_r5_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_wr || slot_wr) |=> !empty_flag);

   // R6: the interrupt needs both its enable and the empty flag
   a_r6_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (irq_en && empty_flag));

   // R7: a new underrun always comes with the line driven
   a_r7_urun_drives: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(urun_flag) |-> sdo_oe);

   // R8: underrun stays set without a clear
   a_r8_urun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (urun_flag && !urun_clr) |=> urun_flag);

endmodule

bind tdm_slot_tx tdm_slot_tx_chk #(.SLOTS(SLOTS), .WORD_W(WORD_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .fsync      (fsync),
   .slot_mask  (slot_mask),
   .hold_wr    (hold_wr),
   .slot_wr    (slot_wr),
   .irq_en     (irq_en),
   .urun_clr   (urun_clr),
   .sdo        (sdo),
   .sdo_oe     (sdo_oe),
   .empty_flag (empty_flag),
   .irq        (irq),
   .urun_flag  (urun_flag)
);

// File: tb/test_tdm_slot_tx.sv
module test_tdm_slot_tx;

   localparam int CLK_P  = 10;
   localparam int SLOTS  = 5;
   localparam int WORD_W = 8;
   localparam int NVEC   = 8;

   // {mask[4:0], kind[1:0] (0 none,1 hold,2 slot), data[7:0], driven[4:0], urun}
   localparam logic [20:0] VEC [NVEC] = '{
      {5'b01001, 2'd1, 8'hA5, 5'b01001, 1'b1},
      {5'b11111, 2'd1, 8'h3C, 5'b11111, 1'b1},
      {5'b00000, 2'd1, 8'hF0, 5'b00000, 1'b0},
      {5'b00100, 2'd0, 8'h00, 5'b00100, 1'b0},
      {5'b00001, 2'd2, 8'h00, 5'b00000, 1'b0},
      {5'b10000, 2'd0, 8'h00, 5'b10000, 1'b1},
      {5'b00010, 2'd1, 8'h81, 5'b00010, 1'b0},
      {5'b01010, 2'd2, 8'h00, 5'b01000, 1'b1}
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              fsync = 1'b0;
   logic [SLOTS-1:0]  slot_mask = '0;
   logic              hold_wr = 1'b0;
   logic [WORD_W-1:0] hold_data = '0;
   logic              slot_wr = 1'b0;
   logic              irq_en = 1'b0;
   logic              urun_clr = 1'b0;
   logic              sdo, sdo_oe, empty_flag, irq, urun_flag;

   int n_checks = 0;
   int n_fail   = 0;
   logic [WORD_W-1:0] hold_m = '0;
   logic empty_m = 1'b1;

   always #(CLK_P/2) clk = ~clk;

   tdm_slot_tx #(.SLOTS(SLOTS), .WORD_W(WORD_W)) i_tdm_slot_tx (
      .clk(clk), .rst_n(rst_n), .fsync(fsync), .slot_mask(slot_mask),
      .hold_wr(hold_wr), .hold_data(hold_data), .slot_wr(slot_wr),
      .irq_en(irq_en), .urun_clr(urun_clr), .sdo(sdo), .sdo_oe(sdo_oe),
      .empty_flag(empty_flag), .irq(irq), .urun_flag(urun_flag)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic do_write(input logic [1:0] kind, input logic [WORD_W-1:0] d);
      if (kind == 2'd1) begin
         hold_wr = 1'b1; hold_data = d; hold_m = d;
      end else if (kind == 2'd2) begin
         slot_wr = 1'b1;
      end
      if (kind != 2'd0) empty_m = 1'b0;
      @(negedge clk);
      hold_wr = 1'b0; slot_wr = 1'b0;
   endtask

   // watchdog
   initial begin
      #(CLK_P * 200000);
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      finish_run();
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      @(negedge clk);
      // R10: reset state
      check("R10 empty", empty_flag, 1);
      check("R10 urun", urun_flag, 0);
      check("R10 oe", sdo_oe, 0);
      check("R10 sdo", sdo, 0);
      check("R6 irq masked", irq, 0);
      irq_en = 1'b1;
      #1 check("R6 irq enabled", irq, 1);

      // vector loop: one frame per entry
      for (int v = 0; v < NVEC; v++) begin
         logic [4:0] m, drv;
         logic [1:0] kind;
         logic [7:0] d;
         logic exp_u;
         int bad;
         {m, kind, d, drv, exp_u} = VEC[v];
         urun_clr = 1'b1; @(negedge clk); urun_clr = 1'b0;
         do_write(kind, d);
         idle(2);
         slot_mask = m;
         fsync = 1'b1;
         bad = 0;
         for (int c = 0; c <= SLOTS * WORD_W; c++) begin
            logic eo, es;
            @(negedge clk);
            if (c < SLOTS * WORD_W) begin
               eo = drv[c / WORD_W];
               es = eo & hold_m[WORD_W - 1 - (c % WORD_W)];
            end else begin
               eo = 1'b0; es = 1'b0;
            end
            if (sdo_oe !== eo || sdo !== es) begin
               bad++;
               $display("FAIL R3/R4 vec %0d cycle %0d actual oe=%b sdo=%b expected oe=%b sdo=%b",
                        v, c, sdo_oe, sdo, eo, es);
            end
            if (c == WORD_W - 1) fsync = 1'b0;
         end
         n_checks++;
         if (bad != 0) n_fail++;
         if (m != 0) empty_m = 1'b1;
         check(exp_u ? "R7 underrun set" : "R9 no underrun", urun_flag, exp_u);
         check("R5 empty after frame", empty_flag, empty_m);
         check("R6 irq follows empty", irq, empty_m);
      end

      // R8: underrun stays until cleared
      idle(5);
      check("R8 urun sticky", urun_flag, 1);
      urun_clr = 1'b1; @(negedge clk); urun_clr = 1'b0;
      check("R8 urun cleared", urun_flag, 0);

      // R5: write in the same cycle as a load wins; old word still sent
      slot_mask = 5'b00001;
      do_write(2'd1, 8'hC3);
      idle(2);
      fsync = 1'b1; hold_wr = 1'b1; hold_data = 8'h11;
      @(negedge clk);
      hold_wr = 1'b0;
      check("R5 concurrent write wins", empty_flag, 0);
      check("R5 old word sent", {sdo_oe, sdo}, 2'b11);
      idle(WORD_W - 1);
      fsync = 1'b0;
      idle(SLOTS * WORD_W);
      check("R2 line released after frame", sdo_oe, 0);

      // R1: frame restart mid-frame (hold now 8'h11 = 0001_0001)
      slot_mask = 5'b11111;
      do_write(2'd1, 8'hC3);
      fsync = 1'b1;
      idle(WORD_W);
      fsync = 1'b0;
      idle(4);
      check("R1 slot1 mid-word oe", sdo_oe, 1);
      fsync = 1'b1;
      @(negedge clk);
      check("R1 restart bit7", {sdo_oe, sdo}, 2'b11);
      @(negedge clk);
      check("R1 restart bit6", {sdo_oe, sdo}, 2'b11);
      @(negedge clk);
      check("R1 restart bit5", {sdo_oe, sdo}, 2'b10);
      fsync = 1'b0;
      idle(SLOTS * WORD_W + 4);
      check("R2 idle after restarted frame", sdo_oe, 0);

      finish_run();
   end

endmodule